// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects up to 32 interrupt sources and presents a single interrupt line to a processor. Each raw request passes through a two-flop synchronizer, and its rising edge is recorded in a source-pending register. A mask register holds one bit per source, and a set bit blocks that source. While the one-hot interrupt-pending register is empty, the controller loads into it the lowest-numbered source that is pending and not masked. The interrupt line stays high as long as that register holds a bit. Software acknowledges a source by writing a one to its bit in the source-pending register and then in the interrupt-pending register.

Below the main level sits a sub-source level with eleven requests. There are three UART groups, each with receive, transmit and error requests, and one analog group with touch and conversion-done requests. Each sub-request has its own pending bit and its own mask bit. A group raises its parent source in the main controller for as long as any of its sub-requests is pending and unmasked. A separate wake-enable register accepts only a fixed set of sources and drives a wake output.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Reset (synchronous, active low) leaves both mask registers all ones and clears the source-pending, interrupt-pending, sub-pending and wake-enable registers. `irq_o` and `wake_o` are low after reset.
- R2: A source-pending bit sets two clock edges after the synchronizer sees a rising edge on its raw request. A request held high does not set the bit again once software has cleared it.
- R3: A source whose mask bit is 1 is still recorded in the source-pending register but is never loaded into the interrupt-pending register. Writing 0 to the mask bit enables the source.
- R4: The interrupt-pending register holds at most one set bit. When it is empty, it loads the lowest-numbered pending, unmasked source on the next clock edge. `irq_o` is high exactly when that register is nonzero.
- R5: The source-pending, interrupt-pending and sub-pending registers are write-one-to-clear. Bits written as 0 keep their value, and an occupied interrupt-pending register holds its value until it is cleared.
- R6: Source positions 6 and 24 are reserved and always read 0, whatever their raw request inputs do.
- R7: The sub-pending bits are laid out as follows: UART0 at 0..2, UART1 at 3..5 and UART2 at 6..8, each group ordered receive, transmit, error; touch at 9 and conversion-done at 10. A rising edge of a synchronized sub-request sets its bit.
- R8: The parents sit at source 28 (UART0), 23 (UART1), 15 (UART2) and 31 (analog). A parent's pending bit is set on every clock edge at which one of its group's sub-pending bits is set with a 0 in the sub-mask register, so clearing the parent alone does not stick while that condition holds. Raw requests at the parent positions are ignored.
- R9: Only sources 0..3 and 30 can be wake-enabled. Other bits written to the wake-enable register read back 0. `wake_o` is high when a wake-enabled source is pending.
- R10: Register word addresses are 0 source-pending, 1 mask, 2 interrupt-pending, 3 sub-pending, 4 sub-mask and 5 wake-enable. Addresses 6 and 7 read 0. Reads are combinational and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 32 | Raw main-source requests (asynchronous) |
| sub_req_i | input | 11 | Raw sub-source requests (asynchronous) |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Wake request |

## Verification
The bench uses the default parameters: 32 sources, three UART groups of three requests, and a two-request analog group with parents at 28, 23, 15 and 31. These values exercise the reserved positions, all four parent scatters, the upper-end source 31 and the wake-allowed position 30. Together they let the lowest-number priority be tested across both halves of the word. The reference model is an independent behavioural description of the same parameter set. It is compared against the interrupt line, the wake line and the addressed register on every clock.

// File: rtl/irq_cascade_pkg.sv
// Shared register selector encoding for the cascaded interrupt controller.
// Assumes word addressing with a 3-bit address.
package irq_cascade_pkg;
    typedef enum logic [2:0] {
        REG_SRCPND = 3'd0,
        REG_MASK   = 3'd1,
        REG_INTPND = 3'd2,
        REG_SUBPND = 3'd3,
        REG_SUBMSK = 3'd4,
        REG_WAKE   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/irq_req_sync.sv
// Two-flop synchronizer plus rising-edge detector for a vector of raw requests.
// Assumes requests are asynchronous levels; rise_o is a one-cycle pulse.
module irq_req_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Synchronizer chain and previous-value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= req_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/irq_sub_stage.sv
// Sub-source level: pending (write-one-to-clear) and mask registers, plus a
// per-group "active" level that feeds one parent source each.
// Assumes NUART groups of three bits at the bottom, then one analog group.
module irq_sub_stage #(
    parameter int NUART    = 3,
    parameter int UART_W   = 3,
    parameter int ADC_W    = 2,
    localparam int NSUB    = NUART * UART_W + ADC_W,
    localparam int NGRP    = NUART + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] rise_i,
    input  logic [NSUB-1:0] clr_i,
    input  logic            mask_we_i,
    input  logic [NSUB-1:0] mask_wdata_i,
    output logic [NSUB-1:0] pend_o,
    output logic [NSUB-1:0] mask_o,
    output logic [NGRP-1:0] grp_act_o
);
    logic [NSUB-1:0] pend_q, mask_q, live;

    // Pending bits: new edges win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | rise_i;
    end

    // Sub-mask register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    assign live = pend_q & ~mask_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g < NUART) begin : g_uart
            assign grp_act_o[g] = |live[g*UART_W +: UART_W];
        end else begin : g_adc
            assign grp_act_o[g] = |live[NUART*UART_W +: ADC_W];
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_main_stage.sv
// Main level: source-pending, mask and one-hot interrupt-pending registers.
// Assumes set_i already excludes reserved positions; lowest index wins.
module irq_main_stage #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] src_clr_i,
    input  logic [NSRC-1:0] ip_clr_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_wdata_i,
    output logic [NSRC-1:0] srcpend_o,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] ipend_o
);
    logic [NSRC-1:0] srcpend_q, mask_q, ipend_q, cand, pick;

    // Source-pending: a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) srcpend_q <= '0;
        else        srcpend_q <= (srcpend_q & ~src_clr_i) | set_i;
    end

    // Main mask register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    assign cand = srcpend_q & ~mask_q;
    assign pick = cand & (~cand + NSRC'(1));

    // Interrupt-pending: load when empty, otherwise hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)              ipend_q <= '0;
        else if (ipend_q == '0)  ipend_q <= pick;
        else                     ipend_q <= ipend_q & ~ip_clr_i;
    end

    assign srcpend_o = srcpend_q;
    assign mask_o    = mask_q;
    assign ipend_o   = ipend_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Top of the two-level interrupt controller: synchronizes requests, scatters
// sub-group levels into parent positions, decodes the register interface and
// drives irq_o / wake_o. Assumes single-cycle word-addressed access.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int          NSRC        = 32,
    parameter int          NUART       = 3,
    parameter int          ADC_W       = 2,
    parameter int          PARENT_POS [NUART+1] = '{28, 23, 15, 31},
    parameter logic [31:0] RSVD_MAP    = 32'h0100_0040,
    parameter logic [31:0] WAKE_ALLOW  = 32'h4000_000F,
    localparam int         NSUB        = NUART * 3 + ADC_W,
    localparam int         NGRP        = NUART + 1,
    localparam int         SIDX_W      = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req_i,
    input  logic [NSUB-1:0] sub_req_i,
    input  logic [2:0]      reg_addr_i,
    input  logic            reg_we_i,
    input  logic [31:0]     reg_wdata_i,
    output logic [31:0]     reg_rdata_o,
    output logic            irq_o,
    output logic            wake_o
);
    function automatic logic [NSRC-1:0] parent_map();
        logic [NSRC-1:0] m = '0;
        for (int g = 0; g < NGRP; g++) m[SIDX_W'(PARENT_POS[g])] = 1'b1;
        return m;
    endfunction
    localparam logic [NSRC-1:0] PAR_MAP = parent_map();

    logic [NSRC-1:0] src_rise, parent_lvl, main_set;
    logic [NSUB-1:0] sub_rise, subpend_q, submask_q;
    logic [NGRP-1:0] grp_act;
    logic [NSRC-1:0] srcpend_q, mask_q, ipend_q, wake_en_q;
    logic            wr_src, wr_msk, wr_ip, wr_sub, wr_smk, wr_wake;

    assign wr_src  = reg_we_i && (reg_addr_i == REG_SRCPND);
    assign wr_msk  = reg_we_i && (reg_addr_i == REG_MASK);
    assign wr_ip   = reg_we_i && (reg_addr_i == REG_INTPND);
    assign wr_sub  = reg_we_i && (reg_addr_i == REG_SUBPND);
    assign wr_smk  = reg_we_i && (reg_addr_i == REG_SUBMSK);
    assign wr_wake = reg_we_i && (reg_addr_i == REG_WAKE);

    irq_req_sync #(.W(NSRC)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .req_i(src_req_i), .rise_o(src_rise)
    );

    irq_req_sync #(.W(NSUB)) u_sub_sync (
        .clk(clk), .rst_n(rst_n), .req_i(sub_req_i), .rise_o(sub_rise)
    );

    irq_sub_stage #(.NUART(NUART), .UART_W(3), .ADC_W(ADC_W)) u_sub (
        .clk(clk), .rst_n(rst_n),
        .rise_i(sub_rise),
        .clr_i(wr_sub ? reg_wdata_i[NSUB-1:0] : '0),
        .mask_we_i(wr_smk),
        .mask_wdata_i(reg_wdata_i[NSUB-1:0]),
        .pend_o(subpend_q),
        .mask_o(submask_q),
        .grp_act_o(grp_act)
    );

    // Scatter each group's active level onto its parent source position.
    always_comb begin
        parent_lvl = '0;
        for (int g = 0; g < NGRP; g++)
            parent_lvl[SIDX_W'(PARENT_POS[g])] = grp_act[g];
    end

    assign main_set = (src_rise & ~(RSVD_MAP[NSRC-1:0] | PAR_MAP)) | parent_lvl;

    irq_main_stage #(.NSRC(NSRC)) u_main (
        .clk(clk), .rst_n(rst_n),
        .set_i(main_set),
        .src_clr_i(wr_src ? reg_wdata_i[NSRC-1:0] : '0),
        .ip_clr_i(wr_ip ? reg_wdata_i[NSRC-1:0] : '0),
        .mask_we_i(wr_msk),
        .mask_wdata_i(reg_wdata_i[NSRC-1:0]),
        .srcpend_o(srcpend_q),
        .mask_o(mask_q),
        .ipend_o(ipend_q)
    );

    // Wake-enable register: only allowed positions can be written to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_en_q <= '0;
        else if (wr_wake) wake_en_q <= reg_wdata_i[NSRC-1:0] & WAKE_ALLOW[NSRC-1:0];
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            REG_SRCPND: reg_rdata_o[NSRC-1:0] = srcpend_q;
            REG_MASK:   reg_rdata_o[NSRC-1:0] = mask_q;
            REG_INTPND: reg_rdata_o[NSRC-1:0] = ipend_q;
            REG_SUBPND: reg_rdata_o[NSUB-1:0] = subpend_q;
            REG_SUBMSK: reg_rdata_o[NSUB-1:0] = submask_q;
            REG_WAKE:   reg_rdata_o[NSRC-1:0] = wake_en_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o  = |ipend_q;
    assign wake_o = |(srcpend_q & wake_en_q);
endmodule

// File: rtl/irq_cascade_chk.sv
// Checker for irq_cascade_ctrl: temporal rules over the pending/mask state.
// Assumes it is bound into the top, where the internal register names resolve.
module irq_cascade_chk #(
    parameter int          NSRC       = 32,
    parameter logic [31:0] RSVD_MAP   = 32'h0100_0040,
    parameter logic [31:0] WAKE_ALLOW = 32'h4000_000F
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] ipend,
    input logic [NSRC-1:0] srcpend,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] wake_en,
    input logic            reg_we_i,
    input logic [2:0]      reg_addr_i
);
    // R4
    ipend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ipend));

    // R6
    reserved_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srcpend & RSVD_MAP[NSRC-1:0]) == '0);

    // R9
    wake_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en & ~WAKE_ALLOW[NSRC-1:0]) == '0);

    // R3
    load_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ipend) == '0 && ipend != '0) |-> ((ipend & $past(mask)) == '0));

    // R4
    load_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ipend) == '0 && ipend != '0) |-> ((ipend & $past(srcpend)) == ipend));

    // R5
    ipend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend != '0 && !(reg_we_i && reg_addr_i == 3'd2)) |=> (ipend == $past(ipend)));
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .NSRC(NSRC), .RSVD_MAP(RSVD_MAP), .WAKE_ALLOW(WAKE_ALLOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ipend(ipend_q), .srcpend(srcpend_q),
    .mask(mask_q), .wake_en(wake_en_q), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i)
);

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// checks per requirement.
module tb_irq_cascade_ctrl;
    logic        clk = 0, rst_n = 0;
    logic [31:0] src_req = '0;
    logic [10:0] sub_req = '0;
    logic [2:0]  addr = '0;
    logic        we = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wake;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_cascade_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .sub_req_i(sub_req),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    // Reference model state.
    logic [31:0] m_src, m_msk, m_ip, m_wk, s1, s2, sp;
    logic [10:0] m_sub, m_smk, t1, t2, tp;
    localparam logic [31:0] RSVD = 32'h0100_0040;
    localparam logic [31:0] PARS = (32'h1 << 28) | (32'h1 << 23) | (32'h1 << 15) | (32'h1 << 31);

    function automatic logic [31:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return m_src;
            3'd1: return m_msk;
            3'd2: return m_ip;
            3'd3: return {21'd0, m_sub};
            3'd4: return {21'd0, m_smk};
            3'd5: return m_wk;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] ed, par, cand, nip;
        logic [10:0] live;
        if (!rst_n) begin
            m_src = 0; m_msk = '1; m_ip = 0; m_wk = 0; m_sub = 0; m_smk = '1;
            s1 = 0; s2 = 0; sp = 0; t1 = 0; t2 = 0; tp = 0;
        end else begin
            ed = s2 & ~sp & ~RSVD & ~PARS;
            live = m_sub & ~m_smk;
            par = 0;
            if (live[2:0] != 0)  par[28] = 1;
            if (live[5:3] != 0)  par[23] = 1;
            if (live[8:6] != 0)  par[15] = 1;
            if (live[10:9] != 0) par[31] = 1;
            cand = m_src & ~m_msk;
            nip = 0;
            if (m_ip == 0) begin
                for (int i = 31; i >= 0; i--) if (cand[i]) nip = 32'h1 << i;
            end else nip = (we && addr == 2) ? (m_ip & ~wdata) : m_ip;
            m_src = ((we && addr == 0) ? (m_src & ~wdata) : m_src) | ed | par;
            m_sub = ((we && addr == 3) ? (m_sub & ~wdata[10:0]) : m_sub) | (t2 & ~tp);
            m_ip = nip;
            if (we && addr == 1) m_msk = wdata;
            if (we && addr == 4) m_smk = wdata[10:0];
            if (we && addr == 5) m_wk = wdata & 32'h4000_000F;
            sp = s2; s2 = s1; s1 = src_req;
            tp = t2; t2 = t1; t1 = sub_req;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R4 irq_o", {31'd0, irq}, {31'd0, m_ip != 0});
            check("R9 wake_o", {31'd0, wake}, {31'd0, (m_src & m_wk) != 0});
            check("R10 read", rdata, mread(addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0; wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a;
        @(posedge clk); #2; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input logic [31:0] v);
        @(negedge clk); src_req = v; idle(3); src_req = 0; idle(5);
    endtask

    initial begin
        logic [31:0] v;
        idle(5); rst_n = 1; idle(1);
        // R1 reset state
        rd(0, v); check("R1 srcpend", v, 0);
        rd(1, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(2, v); check("R1 intpend", v, 0);
        rd(4, v); check("R1 submask", v, 32'h7FF);
        check("R1 irq/wake", {30'd0, irq, wake}, 0);
        // R2 / R3: recorded while masked, no irq
        pulse_src(32'h8);
        rd(0, v); check("R2 srcpend bit3", v, 32'h8);
        rd(2, v); check("R3 masked not loaded", v, 0);
        // R4: two sources together, lowest wins
        wr(1, ~((32'h1 << 3) | (32'h1 << 10)));
        pulse_src(32'h400);
        rd(2, v); check("R4 lowest first", v, 32'h8);
        // R5: zero write keeps bits, ones clear
        wr(0, 0); wr(2, 0);
        rd(2, v); check("R5 zero write keeps", v, 32'h8);
        wr(0, 32'h8); wr(2, 32'h8); idle(2);
        rd(2, v); check("R4 next source loaded", v, 32'h400);
        rd(0, v); check("R5 srcpend cleared bit3", v & 32'h8, 0);
        wr(0, 32'h400); wr(2, 32'h400); idle(2);
        rd(2, v); check("R5 all acked", v, 0);
        // R2: held level does not re-set after clear
        @(negedge clk); src_req = 32'h20; idle(6);
        rd(0, v); check("R2 held sets once", v & 32'h20, 32'h20);
        wr(0, 32'h20); idle(5);
        rd(0, v); check("R2 held no re-set", v & 32'h20, 0);
        src_req = 0; idle(3);
        // R6 / R8: reserved and parent raw inputs ignored
        pulse_src((32'h1 << 6) | (32'h1 << 24) | (32'h1 << 28));
        rd(0, v); check("R6 R8 ignored raw", v, 0);
        // R7: UART1 transmit is sub bit 4
        @(negedge clk); sub_req = 11'h010; idle(3); sub_req = 0; idle(5);
        rd(3, v); check("R7 sub bit4", v, 32'h10);
        rd(0, v); check("R8 sub masked no parent", v & (32'h1 << 23), 0);
        wr(4, 11'h7EF); idle(2);
        rd(0, v); check("R8 parent 23 set", v & (32'h1 << 23), 32'h1 << 23);
        wr(0, 32'h1 << 23); idle(1);
        rd(0, v); check("R8 parent re-sets", v & (32'h1 << 23), 32'h1 << 23);
        wr(3, 32'h10); wr(0, 32'h1 << 23); idle(2);
        rd(0, v); check("R8 parent stays clear", v & (32'h1 << 23), 0);
        // R7 / R8: touch bit 9 -> analog parent 31
        wr(4, 11'h5FF);
        @(negedge clk); sub_req = 11'h200; idle(3); sub_req = 0; idle(5);
        rd(3, v); check("R7 touch bit9", v, 32'h200);
        rd(0, v); check("R8 parent 31", v & (32'h1 << 31), 32'h1 << 31);
        wr(3, 32'h200); wr(0, 32'h1 << 31); idle(2);
        // R9: wake filter and output
        wr(5, 32'hFFFF_FFFF);
        rd(5, v); check("R9 wake allowed only", v, 32'h4000_000F);
        check("R9 wake idle", {31'd0, wake}, 0);
        pulse_src(32'h2);
        check("R9 wake on source1", {31'd0, wake}, 1);
        rd(6, v); check("R10 unused addr", v, 0);
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule